// File: doc/BRIEF.md
# Checkerboard memory tester

This block exercises a small external array of 18-bit words with a checkerboard test. In each pass it first fills every location with a fixed bit pattern on even addresses and its complement on odd addresses. It then reads every location back in ascending order and compares each word against the value it wrote. A second half-pass repeats the fill and read-back with the two words swapped between even and odd addresses. An error-free pass bumps a pass counter, and the test loops forever.

When a read-back word differs in any bit that the operator has not masked, the engine stops with its halt flag raised and shows the failing address on its display bus. The operator then steps through the failure with a continue strobe. The first press shows the expected word, the second shows the word actually read, and the third resumes testing from the very beginning. A switch input masks individual data bits, so that a bit already known to be bad no longer stops the test. While the test is running, the display shows the pass count.

Top module: `ckb_tester`

## Requirements
- R1: While reset is held, halt is 0, display is 0, and the engine presents a write of the base pattern (default 18'h2AAAA) to address 0.
- R2: Half-pass A writes the base pattern to even addresses and its bitwise complement to odd addresses. Half-pass B writes the opposite word to each address. Each half-pass writes addresses 0..DEPTH-1 in ascending order, one word per cycle, and then reads them back in ascending order.
- R3: A read-back word that differs from the expected word in any unmasked bit raises halt and puts the failing address, zero-extended, on display. While halted, no memory write occurs and halt stays high until a continue.
- R4: The first continue after a halt changes display to the expected word for the failing address.
- R5: The second continue changes display to the word actually read.
- R6: The third continue clears halt. The following cycle writes the base pattern to address 0 at the start of half-pass A.
- R7: A data bit whose sw_mask bit is 1 is left out of the compare. A fault confined to masked bits does not halt the test, and a fault in an unmasked bit still does.
- R8: While running, display shows the pass count, which reset clears. The count rises by one when half-pass B finishes without error, exactly 6*DEPTH cycles after each pass begins: one cycle per write, two per read.
- R9: A continue strobe has no effect unless halt is already high, including a strobe that arrives in the same cycle a mismatch is detected.
- R10: After a clean pass the test loops back to half-pass A at address 0, and the pass count keeps accumulating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| sw_mask | input | DATA_W | 1 = ignore this data bit in the compare |
| cont | input | 1 | One-cycle continue strobe |
| halt | output | 1 | High while stopped on a failure |
| display | output | DATA_W | Pass count when running; address, expected or actual word when halted |

## Verification
The continue strobe and the detection of a mismatch can land on the same clock edge. The bench arranges this by placing a stuck-at-one fault at a known address and raising continue exactly in the compare cycle of that address. The strobe must be ignored there: in the cycle after the halt, display must still show the failing address and not the expected word. The bench then runs the normal three-press sequence to confirm that the view counter started from its first step.

// File: rtl/ckb_pkg.sv
package ckb_pkg;
  typedef enum logic [1:0] {
    ST_WRITE = 2'd0,
    ST_ISSUE = 2'd1,
    ST_CHECK = 2'd2,
    ST_HALT  = 2'd3
  } ckb_state_e;

  typedef enum logic [1:0] {
    VW_ADDR = 2'd0,
    VW_EXP  = 2'd1,
    VW_ACT  = 2'd2
  } ckb_view_e;
endpackage

// File: rtl/ckb_pattern.sv
module ckb_pattern #(
  parameter int unsigned DATA_W = 18,
  parameter logic [DATA_W-1:0] SEED = 18'h2AAAA
) (
  input  logic              odd_addr,
  input  logic              swapped,
  output logic [DATA_W-1:0] word
);
  // complement lands on odd addresses in half-pass A, even ones in B
  assign word = (odd_addr ^ swapped) ? ~SEED : SEED;
endmodule

// File: rtl/ckb_compare.sv
module ckb_compare #(
  parameter int unsigned DATA_W = 18
) (
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] ignore,
  output logic              bad
);
  assign bad = |((rd_word ^ exp_word) & ~ignore);
endmodule

// File: rtl/ckb_display.sv
module ckb_display #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                halted,
  input  ckb_pkg::ckb_view_e  view,
  input  logic [ADDR_W-1:0]   fail_addr,
  input  logic [DATA_W-1:0]   exp_word,
  input  logic [DATA_W-1:0]   act_word,
  input  logic [DATA_W-1:0]   pass_cnt,
  output logic [DATA_W-1:0]   shown
);
  import ckb_pkg::*;
  localparam int unsigned PADW = DATA_W - ADDR_W;

  always_comb begin
    if (!halted) begin
      shown = pass_cnt;
    end else begin
      case (view)
        VW_EXP:  shown = exp_word;
        VW_ACT:  shown = act_word;
        default: shown = {{PADW{1'b0}}, fail_addr};
      endcase
    end
  end
endmodule

// File: rtl/ckb_tester.sv
module ckb_tester #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter logic [DATA_W-1:0] SEED = 18'h2AAAA
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] sw_mask,
  input  logic              cont,
  output logic              halt,
  output logic [DATA_W-1:0] display
);
  import ckb_pkg::*;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  ckb_state_e        state_q;
  ckb_view_e         view_q;
  logic [ADDR_W-1:0] addr_q;
  logic              phase_b_q;
  logic [DATA_W-1:0] pass_q;
  logic [DATA_W-1:0] exp_q;
  logic [DATA_W-1:0] act_q;
  logic [DATA_W-1:0] pat_word;
  logic              mismatch;

  ckb_pattern #(.DATA_W(DATA_W), .SEED(SEED)) u_pat (
    .odd_addr (addr_q[0]),
    .swapped  (phase_b_q),
    .word     (pat_word)
  );

  ckb_compare #(.DATA_W(DATA_W)) u_cmp (
    .rd_word  (mem_rdata),
    .exp_word (pat_word),
    .ignore   (sw_mask),
    .bad      (mismatch)
  );

  ckb_display #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_disp (
    .halted    (halt),
    .view      (view_q),
    .fail_addr (addr_q),
    .exp_word  (exp_q),
    .act_word  (act_q),
    .pass_cnt  (pass_q),
    .shown     (display)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_WRITE;
      view_q    <= VW_ADDR;
      addr_q    <= '0;
      phase_b_q <= 1'b0;
      pass_q    <= '0;
      exp_q     <= '0;
      act_q     <= '0;
    end else begin
      case (state_q)
        ST_WRITE: begin
          if (addr_q == LAST) begin
            addr_q  <= '0;
            state_q <= ST_ISSUE;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_ISSUE: state_q <= ST_CHECK;
        ST_CHECK: begin
          if (mismatch) begin
            state_q <= ST_HALT;
            view_q  <= VW_ADDR;
            exp_q   <= pat_word;
            act_q   <= mem_rdata;
          end else if (addr_q == LAST) begin
            addr_q    <= '0;
            state_q   <= ST_WRITE;
            phase_b_q <= ~phase_b_q;
            if (phase_b_q) pass_q <= pass_q + 1'b1;
          end else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        default: begin
          if (cont) begin
            case (view_q)
              VW_ADDR: view_q <= VW_EXP;
              VW_EXP:  view_q <= VW_ACT;
              default: begin
                view_q    <= VW_ADDR;
                state_q   <= ST_WRITE;
                addr_q    <= '0;
                phase_b_q <= 1'b0;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign halt      = (state_q == ST_HALT);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = pat_word;
endmodule

// File: rtl/ckb_tester_chk.sv
module ckb_tester_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 4,
  parameter logic [DATA_W-1:0] SEED = 18'h2AAAA
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              cont,
  input logic              halt,
  input logic [DATA_W-1:0] display
);
  a_r3_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halt |-> !mem_we);

  a_r3_halt_held: assert property (@(posedge clk) disable iff (rst)
    (halt && !cont) |=> halt);

  a_r6_restart_at_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(halt) |-> (mem_we && mem_addr == '0 && mem_wdata == SEED));

  a_r2_word_is_pattern: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == SEED || mem_wdata == ~SEED));

  a_r2_write_ascending: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mem_we && $past(mem_we)) |->
      (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r8_pass_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !halt && !$past(halt) && display != $past(display)) |->
      (display == DATA_W'($past(display) + 1'b1)));
endmodule

bind ckb_tester ckb_tester_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEED(SEED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .cont      (cont),
  .halt      (halt),
  .display   (display)
);

// File: tb/sim_ckb_tester.sv
`timescale 1ns/1ps
module sim_ckb_tester;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam logic [17:0] P  = 18'h2AAAA;
  localparam logic [17:0] NP = 18'h15555;
  localparam int PASS_CYC = 6 * DEPTH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [17:0]   mem_wdata;
  logic [17:0]   mem_rdata;
  logic [17:0]   sw_mask = '0;
  logic          cont = 1'b0;
  logic          halt;
  logic [17:0]   display;

  logic          f_on = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic [17:0]   f_bits = '0;
  logic [17:0]   mem [DEPTH];

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ckb_tester u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sw_mask(sw_mask),
    .cont(cont), .halt(halt), .display(display)
  );

  // memory with an optional stuck-at-one fault on one word
  always_ff @(posedge clk) begin
    if (mem_we)
      mem[mem_addr] <= mem_wdata | ((f_on && mem_addr == f_addr) ? f_bits : 18'h0);
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cont = 1'b0;
    edges(2);
    rst = 1'b0;
  endtask

  task automatic press();
    cont = 1'b1;
    edges(1);
    cont = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    edges(2);
    chk("R1 halt", {17'h0, halt}, 18'h0);
    chk("R1 display", display, 18'h0);
    chk("R1 write en", {17'h0, mem_we}, 18'h1);
    chk("R1 addr", {14'h0, mem_addr}, 18'h0);
    chk("R1 data", mem_wdata, P);
    rst = 1'b0;
  endtask

  task automatic t_clean_pass();
    f_on = 1'b0; sw_mask = '0;
    do_reset();
    edges(1);
    chk("R2 addr1", {14'h0, mem_addr}, 18'h1);
    chk("R2 odd word A", mem_wdata, NP);
    edges(19);
    cont = 1'b1;            // R9 stray strobe while running
    edges(1);
    cont = 1'b0;
    edges(27);              // after edge 48: start of half-pass B
    chk("R2 B addr0 we", {17'h0, mem_we}, 18'h1);
    chk("R2 B even word", mem_wdata, NP);
    edges(1);
    chk("R2 B odd word", mem_wdata, P);
    edges(PASS_CYC - 50);
    chk("R8 count before end", display, 18'h0);
    chk("R9 no halt", {17'h0, halt}, 18'h0);
    edges(1);
    chk("R8 count one", display, 18'h1);
    edges(PASS_CYC);
    chk("R10 count two", display, 18'h2);
  endtask

  task automatic t_fail_a();
    f_on = 1'b1; f_addr = 4'd5; f_bits = 18'h80; sw_mask = '0;
    do_reset();
    edges(27);
    chk("R3 not yet", {17'h0, halt}, 18'h0);
    cont = 1'b1;            // coincides with the mismatch compare
    edges(1);
    cont = 1'b0;
    chk("R3 halt", {17'h0, halt}, 18'h1);
    chk("R3 addr shown", display, 18'h5);
    edges(1);
    chk("R9 same-cycle strobe ignored", display, 18'h5);
    edges(5);
    chk("R3 held", {17'h0, halt}, 18'h1);
    chk("R3 no write", {17'h0, mem_we}, 18'h0);
    press();
    chk("R4 expected", display, NP);
    press();
    chk("R5 actual", display, NP | 18'h80);
    f_on = 1'b0;
    press();
    chk("R6 halt cleared", {17'h0, halt}, 18'h0);
    chk("R6 restart write", {17'h0, mem_we}, 18'h1);
    chk("R6 restart addr", {14'h0, mem_addr}, 18'h0);
    chk("R6 restart word", mem_wdata, P);
    edges(PASS_CYC);
    chk("R6 clean pass after restart", display, 18'h1);
  endtask

  task automatic t_fail_b();
    f_on = 1'b1; f_addr = 4'd4; f_bits = 18'h80; sw_mask = '0;
    do_reset();
    edges(73);
    chk("R2 phase A passes even fault", {17'h0, halt}, 18'h0);
    edges(1);
    chk("R2 halt in B", {17'h0, halt}, 18'h1);
    chk("R3 addr B", display, 18'h4);
    press();
    chk("R4 expected B", display, NP);
    press();
    chk("R5 actual B", display, NP | 18'h80);
  endtask

  task automatic t_mask();
    f_on = 1'b1; f_addr = 4'd5; f_bits = 18'h80; sw_mask = 18'h80;
    do_reset();
    edges(PASS_CYC);
    chk("R7 masked bit no halt", {17'h0, halt}, 18'h0);
    chk("R7 masked pass", display, 18'h1);
    sw_mask = 18'h200;
    do_reset();
    edges(28);
    chk("R7 other bit masked still halts", {17'h0, halt}, 18'h1);
    chk("R7 addr", display, 18'h5);
    f_on = 1'b0; sw_mask = '0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_clean_pass();
    t_fail_a();
    t_fail_b();
    t_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule